// File: doc/BRIEF.md
# Packed Integer Vector Compare-Greater-or-Equal Unit

This unit compares two packed integer vectors lane by lane and returns a mask vector. A result lane is filled with ones when the lane of operand A is greater than or equal to the matching lane of operand B, and with zeros otherwise. At issue time the caller picks the lane width (8, 16 or 32 bits), whether the compare is signed or unsigned, and whether one 64-bit vector or two 64-bit halves (128 bits) are processed.

The caller also supplies the lowest bit of the destination and both source register indices. The unit uses these bits, together with the size code, to flag encodings it cannot execute. An illegal request still produces a result slot one cycle later. That slot has the undefined flag set and an all-zero result, so the caller can raise its trap.

The output stage is a two-state machine. `ST_EMPTY` means no result is presented. `ST_FULL` means the result register holds a fresh result. On every clock edge the machine enters `ST_FULL` when `in_valid` is high (transition "issue") and `ST_EMPTY` when it is low (transition "drain"). These transitions apply from either state. Reset places it in `ST_EMPTY`.

Top module: `vcge_unit`

## Requirements
- R1: Each result lane is all ones when lane A >= lane B under the selected compare, otherwise all zeros; the result lane width equals the operand lane width.
- R2: `size_code` 0 selects 8-bit lanes, 1 selects 16-bit lanes and 2 selects 32-bit lanes. Lane e of a vector occupies bits [e*W +: W], and each 64-bit half holds 64/W lanes.
- R3: `size_code` 3 sets `undef` on the result of that request.
- R4: `is_unsigned` = 1 compares lanes as unsigned numbers; `is_unsigned` = 0 compares them as two's-complement signed numbers.
- R5: `wide` = 0 compares only bits [63:0] and forces result bits [127:64] to zero; `wide` = 1 compares all 128 bits with the same lane rule.
- R6: With `wide` = 1, a 1 on any of `dst_idx_lsb`, `srca_idx_lsb` or `srcb_idx_lsb` sets `undef`. With `wide` = 0 these bits have no effect.
- R7: When `undef` is set, the result is all zeros and `res_valid` is still raised.
- R8: `res_valid` is high in exactly the cycle after a cycle with `in_valid` high, independent of operand values.
- R9: After reset, `res_valid`, `undef` and `res` are all zero.
- R10: While `in_valid` is low, `res` and `undef` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| is_unsigned | input | 1 | 1 = unsigned compare, 0 = signed |
| size_code | input | 2 | Lane width code (0: 8, 1: 16, 2: 32, 3: illegal) |
| wide | input | 1 | 0 = 64-bit vector, 1 = 128-bit vector |
| dst_idx_lsb | input | 1 | Lowest bit of destination register index |
| srca_idx_lsb | input | 1 | Lowest bit of first source register index |
| srcb_idx_lsb | input | 1 | Lowest bit of second source register index |
| res | output | 128 | Registered mask result |
| res_valid | output | 1 | Result strobe, one cycle after request |
| undef | output | 1 | Illegal-encoding flag for the presented result |

## Verification
The assertions check on every cycle the properties that do not depend on arithmetic:
- the fixed one-cycle valid timing;
- that every byte of a valid result is either 0x00 or 0xFF;
- that illegal size codes and odd indices in wide mode raise `undef`;
- that an undefined result is zero;
- that the upper half is cleared in narrow mode;
- that outputs hold while idle.

Whether each lane mask is numerically right is shown only by the bench scenarios. These compare results against a lane model across all six type and size pairings, in both widths, including signed and unsigned extremes, equal operands and zero.

// File: rtl/vcge_pkg.sv
package vcge_pkg;
    localparam int HALF_W   = 64;
    localparam int N_HALVES = 2;
    localparam int VEC_W    = HALF_W * N_HALVES;
    localparam int N_SIZES  = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } lane_sz_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;
endpackage

// File: rtl/vcge_decode.sv
module vcge_decode
    import vcge_pkg::*;
(
    input  logic [1:0] size_code,
    input  logic       wide,
    input  logic       dst_idx_lsb,
    input  logic       srca_idx_lsb,
    input  logic       srcb_idx_lsb,
    output lane_sz_e   lane_sel,
    output logic       illegal
);
    logic bad_size;
    logic bad_align;

    always_comb begin
        lane_sel = lane_sz_e'(size_code);
        bad_size = 1'b0;
        unique case (lane_sel)
            SZ_BYTE, SZ_HALF, SZ_WORD: bad_size = 1'b0;
            SZ_BAD:                    bad_size = 1'b1;
        endcase
        // a 128-bit pair must start on an even register index
        bad_align = wide & (dst_idx_lsb | srca_idx_lsb | srcb_idx_lsb);
        illegal   = bad_size | bad_align;
    end
endmodule

// File: rtl/vcge_half_cmp.sv
module vcge_half_cmp
    import vcge_pkg::*;
#(
    parameter int W = HALF_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_unsigned,
    input  lane_sz_e     lane_sel,
    output logic [W-1:0] mask
);
    logic [W-1:0] msk_by_size [N_SIZES];

    for (genvar gs = 0; gs < N_SIZES; gs++) begin : g_size
        localparam int LW = 8 << gs;
        localparam int NL = W / LW;
        for (genvar gl = 0; gl < NL; gl++) begin : g_lane
            logic [LW-1:0] la;
            logic [LW-1:0] lb;
            logic [LW:0]   xa;
            logic [LW:0]   xb;
            logic          ge;
            always_comb begin
                la = a[gl*LW +: LW];
                lb = b[gl*LW +: LW];
                // one guard bit: sign copy for signed, zero for unsigned
                xa = {~is_unsigned & la[LW-1], la};
                xb = {~is_unsigned & lb[LW-1], lb};
                ge = ($signed(xa) >= $signed(xb));
            end
            assign msk_by_size[gs][gl*LW +: LW] = {LW{ge}};
        end
    end

    always_comb begin
        mask = '0;
        unique case (lane_sel)
            SZ_BYTE: mask = msk_by_size[0];
            SZ_HALF: mask = msk_by_size[1];
            SZ_WORD: mask = msk_by_size[2];
            SZ_BAD:  mask = '0;
        endcase
    end
endmodule

// File: rtl/vcge_unit.sv
module vcge_unit
    import vcge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    input  logic             is_unsigned,
    input  logic [1:0]       size_code,
    input  logic             wide,
    input  logic             dst_idx_lsb,
    input  logic             srca_idx_lsb,
    input  logic             srcb_idx_lsb,
    output logic [VEC_W-1:0] res,
    output logic             res_valid,
    output logic             undef
);
    lane_sz_e         lane_sel;
    logic             illegal;
    logic [VEC_W-1:0] raw_mask;
    logic [VEC_W-1:0] res_d;
    out_state_e       state_q;
    out_state_e       state_d;

    vcge_decode u_dec (
        .size_code    (size_code),
        .wide         (wide),
        .dst_idx_lsb  (dst_idx_lsb),
        .srca_idx_lsb (srca_idx_lsb),
        .srcb_idx_lsb (srcb_idx_lsb),
        .lane_sel     (lane_sel),
        .illegal      (illegal)
    );

    for (genvar gh = 0; gh < N_HALVES; gh++) begin : g_half
        vcge_half_cmp #(.W(HALF_W)) u_cmp (
            .a           (opa[gh*HALF_W +: HALF_W]),
            .b           (opb[gh*HALF_W +: HALF_W]),
            .is_unsigned (is_unsigned),
            .lane_sel    (lane_sel),
            .mask        (raw_mask[gh*HALF_W +: HALF_W])
        );
    end

    // half 0 is always live; upper halves only in wide mode
    always_comb begin
        res_d = raw_mask;
        if (!wide) res_d[VEC_W-1:HALF_W] = '0;
        if (illegal) res_d = '0;
    end

    // next-state: issue -> ST_FULL, drain -> ST_EMPTY
    always_comb begin
        state_d = ST_EMPTY;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res   <= '0;
            undef <= 1'b0;
        end else if (in_valid) begin
            res   <= res_d;
            undef <= illegal;
        end
    end

    assign res_valid = (state_q == ST_FULL);
endmodule

// File: rtl/vcge_checker.sv
module vcge_checker
    import vcge_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       size_code,
    input logic             wide,
    input logic             dst_idx_lsb,
    input logic             srca_idx_lsb,
    input logic             srcb_idx_lsb,
    input logic [VEC_W-1:0] res,
    input logic             res_valid,
    input logic             undef
);
    assert_valid_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    assert_valid_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    assert_bad_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == 2'd3) |=> undef);
    assert_odd_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide && (dst_idx_lsb || srca_idx_lsb || srcb_idx_lsb)) |=> undef);
    assert_undef_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && undef) |-> (res == '0));
    assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (res[VEC_W-1:HALF_W] == '0));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res) && $stable(undef)));

    for (genvar gb = 0; gb < VEC_W/8; gb++) begin : g_byte
        assert_lane_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid |-> (res[gb*8 +: 8] == 8'h00 || res[gb*8 +: 8] == 8'hFF));
    end
endmodule

bind vcge_unit vcge_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .size_code    (size_code),
    .wide         (wide),
    .dst_idx_lsb  (dst_idx_lsb),
    .srca_idx_lsb (srca_idx_lsb),
    .srcb_idx_lsb (srcb_idx_lsb),
    .res          (res),
    .res_valid    (res_valid),
    .undef        (undef)
);

// File: tb/tb_vcge_unit.sv
`timescale 1ns/1ps
module tb_vcge_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic         is_unsigned = 1'b0;
    logic [1:0]   size_code = 2'd0;
    logic         wide = 1'b0;
    logic         dst_idx_lsb = 1'b0;
    logic         srca_idx_lsb = 1'b0;
    logic         srcb_idx_lsb = 1'b0;
    logic [127:0] res;
    logic         res_valid;
    logic         undef;

    int total = 0;
    int bad = 0;
    logic [127:0] last_res;
    logic         last_undef;

    always #4 clk = ~clk;

    vcge_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .is_unsigned(is_unsigned), .size_code(size_code), .wide(wide),
        .dst_idx_lsb(dst_idx_lsb), .srca_idx_lsb(srca_idx_lsb),
        .srcb_idx_lsb(srcb_idx_lsb), .res(res), .res_valid(res_valid), .undef(undef)
    );

    // bit 128 = undefined flag, [127:0] = result
    function automatic logic [128:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input bit uns, input logic [1:0] sz, input bit wd,
                                           input bit di, input bit ai, input bit bi);
        logic [127:0] r;
        int esz;
        int lanes;
        r = '0;
        if (sz == 2'd3 || (wd && (di || ai || bi))) return {1'b1, 128'b0};
        esz = 8 << sz;
        lanes = (wd ? 128 : 64) / esz;
        for (int e = 0; e < lanes; e++) begin
            logic [31:0] la, lb, m, sb;
            m  = (esz == 32) ? 32'hFFFF_FFFF : ((32'd1 << esz) - 32'd1);
            la = 32'(a >> (e * esz)) & m;
            lb = 32'(b >> (e * esz)) & m;
            sb = uns ? 32'd0 : (32'd1 << (esz - 1));
            if ((la ^ sb) >= (lb ^ sb)) r = r | (128'(m) << (e * esz));
        end
        return {1'b0, r};
    endfunction

    task automatic chk(input string tag, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [127:0] a, input logic [127:0] b,
                          input bit uns, input logic [1:0] sz, input bit wd,
                          input bit di, input bit ai, input bit bi);
        logic [128:0] e;
        e = model(a, b, uns, sz, wd, di, ai, bi);
        @(negedge clk);
        in_valid = 1'b1; opa = a; opb = b; is_unsigned = uns; size_code = sz;
        wide = wd; dst_idx_lsb = di; srca_idx_lsb = ai; srcb_idx_lsb = bi;
        @(negedge clk);
        in_valid = 1'b0;
        chk(tag, "res", res, e[127:0]);
        chk(tag, "undef", {127'b0, undef}, {127'b0, e[128]});
        chk("R8", "res_valid", {127'b0, res_valid}, 128'd1);
        last_res = res;
        last_undef = undef;
    endtask

    task automatic idle_check();
        opa = ~opa; opb = ~opb; size_code = ~size_code;
        @(negedge clk);
        chk("R8", "idle res_valid", {127'b0, res_valid}, 128'd0);
        chk("R10", "hold res", res, last_res);
        chk("R10", "hold undef", {127'b0, undef}, {127'b0, last_undef});
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "reset res", res, '0);
        chk("R9", "reset res_valid", {127'b0, res_valid}, '0);
        chk("R9", "reset undef", {127'b0, undef}, '0);
        rst_n = 1'b1;

        // R4 signed vs unsigned extremes, 8-bit lanes
        run_op("R4", {16{8'h80}}, {16{8'h7F}}, 1'b0, 2'd0, 1'b1, 0, 0, 0);
        run_op("R4", {16{8'h80}}, {16{8'h7F}}, 1'b1, 2'd0, 1'b1, 0, 0, 0);
        run_op("R4", {8{16'h8000}}, {8{16'hFFFF}}, 1'b0, 2'd1, 1'b1, 0, 0, 0);
        run_op("R4", {4{32'h7FFF_FFFF}}, {4{32'h8000_0000}}, 1'b1, 2'd2, 1'b1, 0, 0, 0);
        // R1 equal operands and zero
        run_op("R1", 128'h0, 128'h0, 1'b0, 2'd2, 1'b1, 0, 0, 0);
        run_op("R1", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
                     128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b1, 2'd1, 1'b1, 0, 0, 0);
        idle_check();
        // R2 mixed lanes: result pattern depends on lane width
        run_op("R2", 128'h00FF_0100_7F80_0001_00FF_0100_7F80_0001,
                     128'h0100_00FF_807F_0100_0100_00FF_807F_0100, 1'b0, 2'd0, 1'b1, 0, 0, 0);
        run_op("R2", 128'h00FF_0100_7F80_0001_00FF_0100_7F80_0001,
                     128'h0100_00FF_807F_0100_0100_00FF_807F_0100, 1'b0, 2'd1, 1'b1, 0, 0, 0);
        run_op("R2", 128'h00FF_0100_7F80_0001_00FF_0100_7F80_0001,
                     128'h0100_00FF_807F_0100_0100_00FF_807F_0100, 1'b0, 2'd2, 1'b1, 0, 0, 0);
        // R5 narrow mode clears upper half; odd indices ignored (R6)
        run_op("R5", {128{1'b1}}, 128'h0, 1'b1, 2'd0, 1'b0, 0, 0, 0);
        run_op("R6", {128{1'b1}}, 128'h0, 1'b1, 2'd2, 1'b0, 1, 1, 1);
        // R6 odd index in wide mode, each one alone
        run_op("R6", 128'h0, 128'h0, 1'b0, 2'd0, 1'b1, 1, 0, 0);
        run_op("R6", 128'h0, 128'h0, 1'b0, 2'd0, 1'b1, 0, 1, 0);
        run_op("R6", 128'h0, 128'h0, 1'b0, 2'd0, 1'b1, 0, 0, 1);
        // R3 / R7 illegal size gives zero result with valid
        run_op("R3", 128'h0, 128'h0, 1'b1, 2'd3, 1'b0, 0, 0, 0);
        run_op("R7", {128{1'b1}}, 128'h0, 1'b0, 2'd3, 1'b1, 0, 0, 0);
        idle_check();

        // random, all configurations, R1
        for (int i = 0; i < 600; i++) begin
            logic [127:0] ra, rb;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            if (($urandom % 4) == 0) rb = ra;
            if (($urandom % 8) == 0) rb = ra ^ 128'h1;
            run_op("R1", ra, rb, 1'($urandom), 2'($urandom % 3), 1'($urandom),
                   (($urandom % 8) == 0), 1'b0, 1'b0);
            if (($urandom % 5) == 0) idle_check();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule